// File: doc/BRIEF.md
# Superpage Promotion Monitor

This block watches the stream of TLB misses and decides when a run of contiguous virtual pages is worth coalescing into one superpage. Pages are grouped into aligned blocks of sixteen (a group is the miss page number with its low four bits removed). Every miss is charged against its group's counter. Once the counter reaches a programmable ratio N, the block raises a promotion request. N is the cost of copying the group into contiguous physical memory, expressed in units of one miss.

This is a rent-versus-buy rule. Promoting at the break-even point keeps the combined cost of misses and copying within twice the best achievable. The request carries the base page number of the group. It stays up until the promotion handler acknowledges it, and the group's counter is then released. A small table of group counters holds the statistics. When the table is full, a new group takes the place of the least-charged group. The group whose request is outstanding is never evicted.

Top module: `spp_promote_mon`

## Requirements
- R1: While reset is low, `req` is 0 and `req_base` is 0, and the counter table is empty.
- R2: A miss page number belongs to group `vpn >> 4`. Pages with equal upper bits share one counter. `req_base` is the group number shifted left by 4, so its low 4 bits are always zero.
- R3: Each cycle with `miss_vld` high adds one to the counter of the missed group. When a counter is at least `ratio`, `req` rises on the second rising edge after the miss that brought it there. With `ratio` = 1, a single miss is enough.
- R4: `req` and `req_base` hold steady until `ack` is sampled high while `req` is high. On that edge `req` falls and the group's counter is released. A later miss to that group therefore counts again from one.
- R5: A miss to a group without a counter takes the lowest-numbered free entry. If no entry is free, it replaces the entry with the smallest count, with the lower index winning a tie. The new counter starts at one.
- R6: Misses that arrive while a request is outstanding are still counted. Other groups that reach `ratio` wait. After an acknowledge, `req` is low for exactly one cycle, and the qualifying entry with the lowest index is then requested.
- R7: The entry whose request is outstanding is never chosen for replacement, even if its count is the smallest.
- R8: Counters saturate at 255 (all ones of the 8-bit counter) and never wrap back to a small value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_vld | input | 1 | A TLB miss is reported this cycle |
| miss_vpn | input | 24 | Virtual page number of the reported miss |
| ratio | input | 8 | Copy cost in miss units (N); promotion threshold |
| ack | input | 1 | Promotion handler accepts the outstanding request |
| req | output | 1 | Promotion request outstanding |
| req_base | output | 24 | First virtual page number of the group to promote |

## Verification
The bench builds the block with its default parameters: a 24-bit page number, groups of sixteen pages, eight counter entries and an 8-bit counter. With eight entries, nine distinct groups are enough to fill the table and force the smallest-count replacement, including the case where the outstanding entry holds the lowest count. The 8-bit counter lets a few hundred misses drive a counter past 255, so saturation can be told apart from wrap-around through a request that appears only if the count did not wrap.

// File: rtl/spp_pkg.sv
package spp_pkg;
   // request controller state
   typedef enum logic {
      RQ_IDLE = 1'b0,
      RQ_WAIT = 1'b1
   } rq_state_e;
endpackage

// File: rtl/spp_entry_tbl.sv
module spp_entry_tbl #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 20,
   parameter int CNT_W   = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             upd_en,
   input  logic                             upd_new,
   input  logic [$clog2(ENTRIES)-1:0]       upd_idx,
   input  logic [TAG_W-1:0]                 upd_tag,
   input  logic                             clr_en,
   input  logic [$clog2(ENTRIES)-1:0]       clr_idx,
   input  logic [TAG_W-1:0]                 look_tag,
   output logic [ENTRIES-1:0]               vld_o,
   output logic [ENTRIES-1:0][TAG_W-1:0]    tag_o,
   output logic [ENTRIES-1:0][CNT_W-1:0]    cnt_o,
   output logic                             hit_o,
   output logic [$clog2(ENTRIES)-1:0]       hit_idx_o
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [ENTRIES-1:0] match;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      // release wins over a same-cycle update: a miss to the group being
      // acknowledged is absorbed by the promotion
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_o[i] <= 1'b0;
            tag_o[i] <= '0;
            cnt_o[i] <= '0;
         end else if (clr_en && clr_idx == IDX_W'(i)) begin
            vld_o[i] <= 1'b0;
            cnt_o[i] <= '0;
         end else if (upd_en && upd_idx == IDX_W'(i)) begin
            if (upd_new) begin
               vld_o[i] <= 1'b1;
               tag_o[i] <= upd_tag;
               cnt_o[i] <= CNT_W'(1);
            end else if (cnt_o[i] != CNT_MAX) begin
               cnt_o[i] <= cnt_o[i] + CNT_W'(1);
            end
         end
      end
      assign match[i] = vld_o[i] && (tag_o[i] == look_tag);
   end

   always_comb begin
      hit_idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) hit_idx_o = IDX_W'(i);
      end
   end

   assign hit_o = |match;
endmodule

// File: rtl/spp_victim_sel.sv
module spp_victim_sel #(
   parameter int ENTRIES = 8,
   parameter int CNT_W   = 8
) (
   input  logic [ENTRIES-1:0]               vld,
   input  logic [ENTRIES-1:0][CNT_W-1:0]    cnt,
   input  logic                             excl_en,
   input  logic [$clog2(ENTRIES)-1:0]       excl_idx,
   output logic [$clog2(ENTRIES)-1:0]       vic_idx
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int KEY_W = CNT_W + 1;

   // key: free entry = 0, valid entry = its count, protected entry = top
   logic [ENTRIES-1:0][KEY_W-1:0] key;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_key
      always_comb begin
         if (excl_en && excl_idx == IDX_W'(i))
            key[i] = {KEY_W{1'b1}};
         else if (vld[i])
            key[i] = {1'b0, cnt[i]};
         else
            key[i] = '0;
      end
   end

   always_comb begin
      logic [KEY_W-1:0] best;
      best    = {KEY_W{1'b1}};
      vic_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (key[i] < best) begin
            best    = key[i];
            vic_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/spp_req_ctl.sv
module spp_req_ctl
   import spp_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 20,
   parameter int CNT_W   = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ENTRIES-1:0]               vld,
   input  logic [ENTRIES-1:0][TAG_W-1:0]    tag,
   input  logic [ENTRIES-1:0][CNT_W-1:0]    cnt,
   input  logic [CNT_W-1:0]                 ratio,
   input  logic                             ack,
   output logic                             req_o,
   output logic [$clog2(ENTRIES)-1:0]       req_idx_o,
   output logic [TAG_W-1:0]                 req_tag_o
);
   localparam int IDX_W = $clog2(ENTRIES);

   rq_state_e          state;
   logic [ENTRIES-1:0] ready;
   logic               found;
   logic [IDX_W-1:0]   first;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_rdy
      assign ready[i] = vld[i] && (cnt[i] >= ratio);
   end

   always_comb begin
      first = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (ready[i]) first = IDX_W'(i);
      end
   end
   assign found = |ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RQ_IDLE;
         req_idx_o <= '0;
         req_tag_o <= '0;
      end else begin
         case (state)
            RQ_IDLE: if (found) begin
               state     <= RQ_WAIT;
               req_idx_o <= first;
               req_tag_o <= tag[first];
            end
            RQ_WAIT: if (ack) state <= RQ_IDLE;
            default: state <= RQ_IDLE;
         endcase
      end
   end

   assign req_o = (state == RQ_WAIT);
endmodule

// File: rtl/spp_promote_mon.sv
module spp_promote_mon #(
   parameter int VPN_W     = 24,
   parameter int GRP_SHIFT = 4,
   parameter int ENTRIES   = 8,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_vld,
   input  logic [VPN_W-1:0] miss_vpn,
   input  logic [CNT_W-1:0] ratio,
   input  logic             ack,
   output logic             req,
   output logic [VPN_W-1:0] req_base
);
   localparam int TAG_W = VPN_W - GRP_SHIFT;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("spp_promote_mon: ENTRIES must be at least 2");
   end
   if (GRP_SHIFT < 1 || GRP_SHIFT >= VPN_W) begin : g_bad_shift
      $error("spp_promote_mon: GRP_SHIFT out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("spp_promote_mon: CNT_W must be positive");
   end

   logic [TAG_W-1:0]                 grp;
   logic [ENTRIES-1:0]               vld;
   logic [ENTRIES-1:0][TAG_W-1:0]    tag;
   logic [ENTRIES-1:0][CNT_W-1:0]    cnt;
   logic                             hit;
   logic [IDX_W-1:0]                 hit_idx;
   logic [IDX_W-1:0]                 vic_idx;
   logic [IDX_W-1:0]                 req_idx;
   logic [TAG_W-1:0]                 req_tag;

   assign grp = miss_vpn[VPN_W-1:GRP_SHIFT];

   spp_entry_tbl #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (miss_vld),
      .upd_new   (!hit),
      .upd_idx   (hit ? hit_idx : vic_idx),
      .upd_tag   (grp),
      .clr_en    (req && ack),
      .clr_idx   (req_idx),
      .look_tag  (grp),
      .vld_o     (vld),
      .tag_o     (tag),
      .cnt_o     (cnt),
      .hit_o     (hit),
      .hit_idx_o (hit_idx)
   );

   spp_victim_sel #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_vic (
      .vld      (vld),
      .cnt      (cnt),
      .excl_en  (req),
      .excl_idx (req_idx),
      .vic_idx  (vic_idx)
   );

   spp_req_ctl #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld       (vld),
      .tag       (tag),
      .cnt       (cnt),
      .ratio     (ratio),
      .ack       (ack),
      .req_o     (req),
      .req_idx_o (req_idx),
      .req_tag_o (req_tag)
   );

   assign req_base = {req_tag, {GRP_SHIFT{1'b0}}};
endmodule

// File: rtl/spp_promote_mon_chk.sv
module spp_promote_mon_chk #(
   parameter int VPN_W     = 24,
   parameter int GRP_SHIFT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic             ack,
   input logic [VPN_W-1:0] req_base
);
   // R1: no request while reset is applied
   always @(posedge clk) begin
      a_r1_quiet_in_reset: assert (rst_n || !req)
         else $error("a_r1_quiet_in_reset");
   end

   // R2: requested base is group aligned
   a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (req_base[GRP_SHIFT-1:0] == '0));

   // R4: request and base held until acknowledged
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(req_base)));

   // R4 / R6: acknowledge drops the request for a cycle
   a_r6_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack) |=> !req);
endmodule

bind spp_promote_mon spp_promote_mon_chk #(.VPN_W(VPN_W), .GRP_SHIFT(GRP_SHIFT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .ack      (ack),
   .req_base (req_base)
);

// File: tb/tb_spp_promote_mon.sv
module tb_spp_promote_mon;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_vld = 1'b0;
   logic [23:0] miss_vpn = '0;
   logic [7:0]  ratio = 8'd1;
   logic        ack = 1'b0;
   logic        req;
   logic [23:0] req_base;

   int checks = 0;
   int errors = 0;
   bit seen = 1'b0;
   logic [23:0] exp_q[$];
   string       tag_q[$];

   spp_promote_mon dut (
      .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_vpn(miss_vpn),
      .ratio(ratio), .ack(ack), .req(req), .req_base(req_base)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   // scoreboard monitor: each new request is compared to the queue head
   always @(negedge clk) begin
      if (rst_n && req && !seen) begin
         seen = 1'b1;
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected request", {8'h0, req_base}, 32'h0);
         end else begin
            logic [23:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(req_base == e, t, {8'h0, req_base}, {8'h0, e});
         end
      end
      if (!req) seen = 1'b0;
   end

   task automatic expect_req(input logic [23:0] b, input string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic miss(input logic [23:0] vpn);
      miss_vld = 1'b1;
      miss_vpn = vpn;
      @(negedge clk);
      miss_vld = 1'b0;
   endtask

   task automatic give_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      miss_vld = 1'b0;
      ack = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      idle(2);
      // R1: reset state
      check(req == 1'b0, "R1 req in reset", {31'h0, req}, 32'h0);
      check(req_base == '0, "R1 base in reset", {8'h0, req_base}, 32'h0);
      rst_n = 1'b1;
      idle(1);

      // R2 / R3: grouping and threshold, ratio 3
      ratio = 8'd3;
      miss(24'd79);
      miss(24'd80);
      idle(2);
      check(req == 1'b0, "R2 pages 79 and 80 in different groups", {31'h0, req}, 32'h0);
      miss(24'd64);
      idle(2);
      check(req == 1'b0, "R3 below ratio", {31'h0, req}, 32'h0);
      expect_req(24'd64, "R2 base of group 64..79");
      miss(24'd70);
      idle(1);
      check(req == 1'b1, "R3 request after ratio reached", {31'h0, req}, 32'h1);
      // R4: hold
      idle(5);
      check(req == 1'b1 && req_base == 24'd64, "R4 held until ack", {8'h0, req_base}, 32'd64);
      give_ack();
      check(req == 1'b0, "R4 drop after ack", {31'h0, req}, 32'h0);
      miss(24'd65);
      miss(24'd66);
      idle(3);
      check(req == 1'b0, "R4 counter restarted", {31'h0, req}, 32'h0);
      expect_req(24'd64, "R4 group requested again after restart");
      miss(24'd67);
      idle(2);
      give_ack();

      // R3: ratio of one
      do_reset();
      ratio = 8'd1;
      expect_req(24'h123450, "R3 ratio 1 single miss");
      miss(24'h12345A);
      idle(1);
      check(req == 1'b1, "R3 ratio 1 timing", {31'h0, req}, 32'h1);
      idle(1);
      give_ack();

      // R6: counting while pending
      do_reset();
      ratio = 8'd2;
      expect_req(24'h000100, "R6 first group");
      miss(24'h000100);
      miss(24'h00010F);
      idle(2);
      miss(24'h000201);
      miss(24'h000202);
      miss(24'h000203);
      idle(3);
      check(req == 1'b1 && req_base == 24'h000100, "R6 waiting group does not displace",
            {8'h0, req_base}, 32'h100);
      expect_req(24'h000200, "R6 waiting group requested after ack");
      give_ack();
      check(req == 1'b0, "R6 one-cycle gap", {31'h0, req}, 32'h0);
      idle(1);
      check(req == 1'b1, "R6 next request after gap", {31'h0, req}, 32'h1);
      give_ack();

      // R5: replacement of smallest count
      do_reset();
      ratio = 8'd4;
      for (int k = 0; k < 8; k++) begin
         int n;
         n = (k == 5 || k == 6) ? 1 : 3;
         for (int j = 0; j < n; j++) miss(24'((k + 1) * 256 + j));
      end
      miss(24'(9 * 256));
      for (int j = 0; j < 3; j++) miss(24'(6 * 256 + 1));
      idle(3);
      check(req == 1'b0, "R5 lowest-index smallest count evicted", {31'h0, req}, 32'h0);
      expect_req(24'(7 * 256), "R5 surviving small entry keeps its count");
      for (int j = 0; j < 3; j++) miss(24'(7 * 256 + 2));
      idle(2);
      give_ack();

      // R7: outstanding entry protected
      do_reset();
      ratio = 8'd2;
      expect_req(24'h000010, "R7 first request");
      miss(24'h000010);
      miss(24'h000011);
      idle(2);
      for (int k = 1; k < 8; k++)
         for (int j = 0; j < 3; j++) miss(24'((k + 1) * 16 + j));
      miss(24'(9 * 16));
      idle(2);
      check(req == 1'b1 && req_base == 24'h000010, "R7 pending base unchanged",
            {8'h0, req_base}, 32'h10);
      expect_req(24'h000030, "R7 replacement skipped pending entry");
      give_ack();
      idle(2);
      give_ack();

      // R8: saturation
      do_reset();
      ratio = 8'd255;
      expect_req(24'h00A000, "R8 first group at 255");
      for (int j = 0; j < 255; j++) miss(24'h00A000);
      idle(2);
      for (int j = 0; j < 300; j++) miss(24'h00B003);
      expect_req(24'h00B000, "R8 counter saturated, no wrap");
      give_ack();
      idle(2);
      check(req == 1'b1, "R8 saturated group requested", {31'h0, req}, 32'h1);
      give_ack();
      idle(3);

      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
      summary();
      $finish;
   end
endmodule